// File: doc/BRIEF.md
# Reference Divider and Periodic Rate Generator

This block sits beside a timekeeping core and turns a slow reference clock into the timing events that core needs. The reference arrives as a one-cycle enable strobe `ref_en` inside a fast system clock domain. A prescaler first brings any of the three supported reference rates to a common stage rate of 32 768 strobes per second. A binary chain then counts stage ticks down to a once-per-second update pulse `sec_tick`.

The same chain feeds a 4-bit rate selector. The selector picks one power-of-two tap of the chain. That tap drives a square-wave output and a one-cycle periodic pulse. The square-wave output can be gated off. An update-busy flag `uip` opens a fixed number of stage ticks before each second boundary and closes a fixed number of stage ticks after it. Consumers treat its high phase as the window in which time values must not be sampled.

A 3-bit divider-control code selects the reference rate. Two of its codes hold the whole chain in reset. On leaving that state, the chain starts half-way through a second, so the first update falls half a second later.

Top module: `rtc_divider_chain`

## Requirements
- R1: While `rst_n` is low, or while `div_ctl` is 6 or 7 (both upper bits set), `sec_tick`, `pi_pulse` and `uip` stay low. In that state the divider neither counts nor advances.
- R2: With `div_ctl` = 2, every `ref_en` strobe is one stage tick, and `sec_tick` repeats every 32 768 stage ticks. Codes 3, 4 and 5 behave exactly like code 2.
- R3: With `div_ctl` = 0, one stage tick occurs per 128 `ref_en` strobes. With `div_ctl` = 1, one stage tick occurs per 32 strobes.
- R4: When `div_ctl` leaves 6/7 for a running code, the first `sec_tick` comes 16 384 stage ticks later.
- R5: For `rate_sel` = n with n from 2 to 15, `pi_pulse` fires once every 2^(n-1) stage ticks. Each pulse is one system clock wide when that spacing exceeds one clock.
- R6: For `rate_sel` = 1, `pi_pulse` fires on every stage tick.
- R7: For `rate_sel` = 0, `pi_pulse` and `sqw_out` stay low.
- R8: `sqw_out` is low whenever `sqw_en` is low. When `sqw_en` is high and n is from 2 to 15, `sqw_out` is a 50 % square wave that holds each level for 2^(n-2) stage ticks. Rate 1 yields the same wave as rate 2.
- R9: `uip` rises exactly 8 stage ticks before each `sec_tick` and is high while `sec_tick` is high.
- R10: `uip` falls exactly 65 stage ticks after each `sec_tick`, so it is high for 73 stage ticks in total.
- R11: System cycles without a `ref_en` strobe advance nothing. Stage ticks, pulses and the second count move only on strobes.
- R12: `sec_tick` is one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle strobe per reference clock period |
| div_ctl | input | 3 | Reference rate select / divider hold code |
| rate_sel | input | 4 | Periodic tap select, 0 = off |
| sqw_en | input | 1 | Square-wave output enable |
| sec_tick | output | 1 | One-cycle pulse at each one-second update |
| pi_pulse | output | 1 | One-cycle periodic-interrupt pulse |
| sqw_out | output | 1 | Selected square wave, gated by `sqw_en` |
| uip | output | 1 | Update-busy window flag |

## Verification
The bound checker watches several properties on every cycle:
- quiet outputs while the divider is held;
- no stage tick without a reference strobe;
- pulses arising only from stage ticks;
- the rate-off and enable gating of the square wave;
- `uip` enclosing each update pulse;
- single-cycle update pulses.

The exact spacings can only be shown by the bench's scenarios. These cover the half-second first update, the 32 768-tick second, the 8-tick lead and 65-tick tail of `uip`, every rate's pulse spacing and square-wave half period, and the two prescale ratios. The bench measures them as cycle counts between observed output edges.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef enum logic [1:0] {
    REF_FAST = 2'd0,
    REF_MID  = 2'd1,
    REF_SLOW = 2'd2,
    REF_HOLD = 2'd3
  } ref_mode_e;

  // Divider control code to reference mode; codes with both upper bits set hold.
  function automatic ref_mode_e decode_ctl(input logic [2:0] code);
    if (code[2:1] == 2'b11) return REF_HOLD;
    if (code == 3'd0)       return REF_FAST;
    if (code == 3'd1)       return REF_MID;
    return REF_SLOW;
  endfunction

  // Level of the chain tap picked by a rate code (rate 1 shares rate 2's tap).
  function automatic logic tap_level(input logic [31:0] cnt, input logic [3:0] rate);
    logic [31:0] shifted;
    if (rate == 4'd0) return 1'b0;
    if (rate == 4'd1) return cnt[0];
    shifted = cnt >> ({28'd0, rate} - 32'd2);
    return shifted[0];
  endfunction

  // True when the given next chain value is a rising edge of the picked tap.
  function automatic logic tap_rise(input logic [31:0] nxt, input logic [3:0] rate);
    logic [31:0] k;
    logic [31:0] low_mask;
    logic [31:0] shifted;
    if (rate == 4'd0) return 1'b0;
    if (rate == 4'd1) return 1'b1;
    k        = {28'd0, rate} - 32'd2;
    low_mask = (32'd1 << k) - 32'd1;
    shifted  = nxt >> k;
    return shifted[0] && ((nxt & low_mask) == 32'd0);
  endfunction

endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler
  import rtc_div_pkg::*;
#(
  parameter int unsigned FAST_BITS = 7,
  parameter int unsigned MID_BITS  = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_en,
  input  ref_mode_e mode,
  output logic      stage_tick
);

  localparam logic [FAST_BITS-1:0] FAST_MASK = {FAST_BITS{1'b1}};
  localparam logic [FAST_BITS-1:0] MID_MASK  = FAST_BITS'((64'd1 << MID_BITS) - 64'd1);

  logic [FAST_BITS-1:0] pre_q;
  logic [FAST_BITS-1:0] mask;
  logic                 pre_full;

  always_comb begin
    case (mode)
      REF_FAST: mask = FAST_MASK;
      REF_MID:  mask = MID_MASK;
      default:  mask = '0;
    endcase
  end

  assign pre_full   = ((pre_q & mask) == mask);
  assign stage_tick = ref_en && (mode != REF_HOLD) && pre_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (mode == REF_HOLD) pre_q <= '0;
    else if (ref_en)           pre_q <= pre_full ? '0 : pre_q + 1'b1;
  end

endmodule

// File: rtl/second_chain.sv
module second_chain #(
  parameter int unsigned SEC_BITS = 15,
  parameter int unsigned LEAD     = 8,
  parameter int unsigned UPD_LEN  = 65
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                stage_tick,
  output logic [SEC_BITS-1:0] cnt_nxt,
  output logic                sec_tick,
  output logic                uip
);

  localparam logic [SEC_BITS-1:0] HALF    = SEC_BITS'(64'd1 << (SEC_BITS - 1));
  localparam logic [SEC_BITS-1:0] LEAD_AT = SEC_BITS'((64'd1 << SEC_BITS) - 64'(LEAD) - 64'd1);
  localparam int unsigned         UW      = $clog2(UPD_LEN + 1);
  localparam logic [UW-1:0]       UPD_INIT = UW'(UPD_LEN);

  logic [SEC_BITS-1:0] cnt_q;
  logic [UW-1:0]       upd_left;
  logic                wrap;
  logic                lead_hit;

  assign cnt_nxt  = hold ? HALF : (stage_tick ? cnt_q + 1'b1 : cnt_q);
  assign wrap     = stage_tick && (&cnt_q);
  assign lead_hit = stage_tick && (cnt_q == LEAD_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= HALF;
      sec_tick <= 1'b0;
      uip      <= 1'b0;
      upd_left <= '0;
    end else begin
      cnt_q    <= cnt_nxt;
      sec_tick <= wrap;
      if (hold) begin
        uip      <= 1'b0;
        upd_left <= '0;
      end else if (wrap) begin
        upd_left <= UPD_INIT;
      end else if (lead_hit) begin
        uip <= 1'b1;
      end else if (stage_tick && (upd_left != '0)) begin
        upd_left <= upd_left - 1'b1;
        if (upd_left == UW'(1)) uip <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/periodic_tap.sv
module periodic_tap
  import rtc_div_pkg::*;
#(
  parameter int unsigned SEC_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stage_tick,
  input  logic [SEC_BITS-1:0] cnt_nxt,
  input  logic [3:0]          rate_sel,
  input  logic                sqw_en,
  output logic                pi_pulse,
  output logic                sqw_out
);

  logic [31:0] cnt_wide;

  assign cnt_wide = 32'(cnt_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_pulse <= 1'b0;
      sqw_out  <= 1'b0;
    end else begin
      pi_pulse <= stage_tick && tap_rise(cnt_wide, rate_sel);
      sqw_out  <= sqw_en && tap_level(cnt_wide, rate_sel);
    end
  end

endmodule

// File: rtl/rtc_divider_chain.sv
module rtc_divider_chain
  import rtc_div_pkg::*;
#(
  parameter int unsigned FAST_BITS = 7,
  parameter int unsigned MID_BITS  = 5,
  parameter int unsigned SEC_BITS  = 15,
  parameter int unsigned LEAD      = 8,
  parameter int unsigned UPD_LEN   = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic [2:0] div_ctl,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  output logic       sec_tick,
  output logic       pi_pulse,
  output logic       sqw_out,
  output logic       uip
);

  ref_mode_e           mode;
  logic                hold;
  logic                stage_tick;
  logic [SEC_BITS-1:0] cnt_nxt;

  assign mode = decode_ctl(div_ctl);
  assign hold = (mode == REF_HOLD);

  ref_prescaler #(
    .FAST_BITS (FAST_BITS),
    .MID_BITS  (MID_BITS)
  ) pre_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_en     (ref_en),
    .mode       (mode),
    .stage_tick (stage_tick)
  );

  second_chain #(
    .SEC_BITS (SEC_BITS),
    .LEAD     (LEAD),
    .UPD_LEN  (UPD_LEN)
  ) sec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .stage_tick (stage_tick),
    .cnt_nxt    (cnt_nxt),
    .sec_tick   (sec_tick),
    .uip        (uip)
  );

  periodic_tap #(
    .SEC_BITS (SEC_BITS)
  ) tap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_tick (stage_tick),
    .cnt_nxt    (cnt_nxt),
    .rate_sel   (rate_sel),
    .sqw_en     (sqw_en),
    .pi_pulse   (pi_pulse),
    .sqw_out    (sqw_out)
  );

endmodule

// File: rtl/rtc_divider_chain_chk.sv
module rtc_divider_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_en,
  input logic [2:0] div_ctl,
  input logic [3:0] rate_sel,
  input logic       sqw_en,
  input logic       stage_tick,
  input logic       sec_tick,
  input logic       pi_pulse,
  input logic       sqw_out,
  input logic       uip
);

  assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |=> (!sec_tick && !pi_pulse && !uip));

  assert_tick_from_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(stage_tick));

  assert_pulse_from_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pi_pulse |-> $past(stage_tick));

  assert_rate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> (!pi_pulse && !sqw_out));

  assert_sqw_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |=> !sqw_out);

  assert_uip_covers_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> uip);

  assert_no_strobe_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |-> !stage_tick);

  assert_tick_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

endmodule

bind rtc_divider_chain rtc_divider_chain_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_en     (ref_en),
  .div_ctl    (div_ctl),
  .rate_sel   (rate_sel),
  .sqw_en     (sqw_en),
  .stage_tick (stage_tick),
  .sec_tick   (sec_tick),
  .pi_pulse   (pi_pulse),
  .sqw_out    (sqw_out),
  .uip        (uip)
);

// File: tb/rtc_divider_chain_tb_top.sv
`timescale 1ns/1ps
module rtc_divider_chain_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b1;
  logic [2:0] div_ctl = 3'd2;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       sec_tick, pi_pulse, sqw_out, uip;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ref_period = 1;
  int ref_phase = 0;

  always #2.5 clk = ~clk;

  rtc_divider_chain dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .div_ctl  (div_ctl),
    .rate_sel (rate_sel),
    .sqw_en   (sqw_en),
    .sec_tick (sec_tick),
    .pi_pulse (pi_pulse),
    .sqw_out  (sqw_out),
    .uip      (uip)
  );

  // Reference strobe: one cycle in every ref_period.
  always @(negedge clk) begin
    if (ref_period <= 1) begin
      ref_en = 1'b1;
      ref_phase = 0;
    end else begin
      ref_en = (ref_phase == 0);
      ref_phase = (ref_phase + 1) % ref_period;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cycles, 195000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int which);
    case (which)
      0: return sec_tick;
      1: return pi_pulse;
      2: return sqw_out;
      default: return uip;
    endcase
  endfunction

  // Posedges from the current negedge until the chosen output shows lvl.
  task automatic count_until(input int which, input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (sig(which) !== lvl);
  endtask

  // Spacing between two consecutive periodic pulses.
  task automatic pulse_spacing(output int n);
    int dummy;
    count_until(1, 1'b1, dummy);
    count_until(1, 1'b1, n);
  endtask

  // Counts of high cycles on sec_tick, pi_pulse, sqw_out, uip over a window.
  task automatic quiet_window(input int len, output int s, output int p, output int q, output int u);
    s = 0; p = 0; q = 0; u = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s += int'(sec_tick); p += int'(pi_pulse); q += int'(sqw_out); u += int'(uip);
    end
  endtask

  initial begin
    int n, s, p, q, u, total;
    repeat (5) @(negedge clk);
    chk(!sec_tick && !pi_pulse && !sqw_out && !uip, "R1 reset outputs",
        int'({sec_tick, pi_pulse, sqw_out, uip}), 0);

    // R1: held divider codes
    div_ctl = 3'd6; rate_sel = 4'd3; sqw_en = 1'b1;
    rst_n = 1'b1;
    quiet_window(300, s, p, q, u);
    chk(s + p + u == 0, "R1 hold code 6 activity", s + p + u, 0);
    div_ctl = 3'd7;
    quiet_window(100, s, p, q, u);
    chk(s + p + u == 0, "R1 hold code 7 activity", s + p + u, 0);

    // R4, R12, R10, R9, R2: release and follow one second
    div_ctl = 3'd2;
    count_until(0, 1'b1, n);
    chk(n == 16384, "R4 first update after release", n, 16384);
    total = 0;
    count_until(3, 1'b0, n);
    chk(n == 65, "R10 uip tail after update", n, 65);
    total += n;
    count_until(3, 1'b1, n);
    chk(n == 32695, "R9 uip quiet span", n, 32695);
    total += n;
    count_until(0, 1'b1, n);
    chk(n == 8, "R9 uip lead before update", n, 8);
    total += n;
    chk(total == 32768, "R2 update spacing", total, 32768);
    @(negedge clk);
    chk(!sec_tick, "R12 update pulse width", int'(sec_tick), 0);

    // R5, R6, R8: sweep all rate codes
    for (int r = 1; r <= 15; r++) begin
      rate_sel = 4'(r);
      pulse_spacing(n);
      if (r == 1) chk(n == 1, "R6 rate 1 spacing", n, 1);
      else        chk(n == (1 << (r - 1)), $sformatf("R5 rate %0d spacing", r), n, 1 << (r - 1));
      if (r >= 3) begin
        @(negedge clk);
        chk(!pi_pulse, $sformatf("R5 rate %0d pulse width", r), int'(pi_pulse), 0);
      end
      if (r <= 12) begin
        count_until(2, 1'b0, n);
        count_until(2, 1'b1, n);
        count_until(2, 1'b0, n);
        if (r == 1) chk(n == 1, "R8 rate 1 half period", n, 1);
        else        chk(n == (1 << (r - 2)), $sformatf("R8 rate %0d half period", r), n, 1 << (r - 2));
      end
    end

    // R7: rate off
    rate_sel = 4'd0;
    @(negedge clk);
    quiet_window(300, s, p, q, u);
    chk(p + q == 0, "R7 rate 0 activity", p + q, 0);

    // R8: enable gating
    rate_sel = 4'd4; sqw_en = 1'b0;
    @(negedge clk);
    quiet_window(100, s, p, q, u);
    chk(q == 0, "R8 gated square wave", q, 0);
    chk(p > 0, "R8 pulses continue while gated", p, 12);

    // R11: sparse strobes
    ref_period = 3; rate_sel = 4'd2;
    pulse_spacing(n);
    chk(n == 6, "R11 rate 2 with strobe every 3", n, 6);
    rate_sel = 4'd1;
    pulse_spacing(n);
    chk(n == 3, "R11 rate 1 with strobe every 3", n, 3);
    ref_period = 1;

    // R3: prescaled references; R2: alias codes
    div_ctl = 3'd0;
    pulse_spacing(n);
    chk(n == 128, "R3 code 0 stage spacing", n, 128);
    div_ctl = 3'd1;
    pulse_spacing(n);
    chk(n == 32, "R3 code 1 stage spacing", n, 32);
    for (int c = 3; c <= 5; c++) begin
      div_ctl = 3'(c);
      pulse_spacing(n);
      chk(n == 1, $sformatf("R2 code %0d stage spacing", c), n, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule